// File: doc/BRIEF.md
# Dual Pattern FIFO with Sticky Overflow Flags

This block holds two independent four-entry queues. Each entry pairs an 8-bit timing value with an 8-bit output pattern word, and both halves are always written and read together. A CPU-side port pushes one entry per cycle into either queue. A consumer-side pop port drains each queue separately and shows the head entry of each queue continuously.

A small control/status register serves both queues. For each queue it holds a command bit that empties the queue when written with 1, a sticky overflow flag, and a read-only full indication. A push aimed at a full queue is thrown away. The rejected push latches that queue's overflow flag, and the flag drives the interrupt line. Only software can lower the flag, by writing 0 to its bit. Software is expected to wait until a slot frees up before it offers the data again.

Top module: `dual_pattern_fifo`

## Requirements
- R1: After reset, `csr_rdata` reads 0, `irq` is 0 and both queues are empty (`head_valid` = 00).
- R2: Queue k (k=0 for the first queue, k=1 for the second) is selected by `ent_sel` = k. A push stores {timing, pattern} as one entry. Pops return entries in first-in first-out order, with timing on `head_timing[8k+7:8k]` and pattern on `head_pattern[8k+7:8k]`, valid when `head_valid[k]` is 1.
- R3: A queue holding 4 entries reports full. The first queue's full bit is `csr_rdata[4]` and the second queue's full bit is `csr_rdata[5]`. Writes to these bits are ignored.
- R4: A push to a full queue is discarded, and that queue's stored contents and order are unchanged.
- R5: A discarded push sets the overflow flag of that queue on the next clock edge. The first queue's flag is `csr_rdata[2]` and the second queue's flag is `csr_rdata[3]`.
- R6: An overflow flag stays set until a CSR write carries 0 in its bit. A CSR write with 1 in that bit leaves the flag unchanged.
- R7: If an overflow and a clearing CSR write happen in the same cycle, the flag ends up set.
- R8: `irq` is 1 exactly when at least one overflow flag is set.
- R9: A CSR write with 1 in bit 0 (first queue) or bit 1 (second queue) empties that queue by resetting its read pointer, write pointer and count. These bits always read 0. A 0 in them has no effect. Any push to that queue in the same cycle is dropped and raises no flag.
- R10: Pushes, pops, flags and clears of one queue never change the other queue's state.
- R11: A pop of an empty queue is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_we | input | 1 | Push strobe for one entry |
| ent_sel | input | 1 | Target queue of the push (0 first, 1 second) |
| ent_timing | input | 8 | Timing half of the pushed entry |
| ent_pattern | input | 8 | Pattern half of the pushed entry |
| csr_we | input | 1 | Control/status register write strobe |
| csr_wdata | input | 4 | Written value: [0],[1] clear commands, [2],[3] overflow flag writes |
| csr_rdata | output | 6 | {full2, full1, ovf2, ovf1, 0, 0} |
| pop_req | input | 2 | Per-queue pop strobe |
| head_valid | output | 2 | Per-queue head entry present |
| head_timing | output | 16 | Head timing values, first queue in the low byte |
| head_pattern | output | 16 | Head pattern values, first queue in the low byte |
| irq | output | 1 | Overflow interrupt |

## Verification
The bound checker watches the flag behaviour on every cycle. A rejected push must raise its flag on the next edge, even when a clearing write arrives in the same cycle. A set flag must survive every write that does not carry a 0 for it, and `irq` may rise only after an overflow event. A clear command must leave its queue empty, and a pop of an empty queue must not make it non-empty. Ordering and data integrity cannot be shown by a property: that the dropped fifth entry never reaches the head, that entries come out in push order with their two halves paired, and that one queue is untouched by traffic on the other. These come from the bench's queue model and its directed scenarios.

// File: rtl/dpf_pkg.sv
package dpf_pkg;
  localparam int NUM_Q    = 2;
  localparam int CLR_LSB  = 0;
  localparam int OVF_LSB  = 2;
  localparam int FULL_LSB = 4;
  localparam int CSR_WW   = 4;
  localparam int CSR_RW   = 6;

  // Next pointer value with wrap at depth (depth need not be a power of two).
  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // Occupancy after one cycle of accepted pushes and pops.
  function automatic int unsigned next_count(int unsigned c, logic add, logic sub);
    return c + (add ? 1 : 0) - (sub ? 1 : 0);
  endfunction
endpackage

// File: rtl/pattern_fifo.sv
module pattern_fifo #(
  parameter int DEPTH = 4,
  parameter int EW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [EW-1:0] din,
  output logic          full,
  output logic          valid,
  output logic [EW-1:0] dout,
  output logic          overflow
);
  import dpf_pkg::*;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          accept, take;

  assign full     = (count == CW'(DEPTH));
  assign valid    = (count != '0);
  assign accept   = push && !full && !flush;
  assign overflow = push && full && !flush;
  assign take     = pop && valid && !flush;
  assign dout     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) wr_ptr <= AW'(wrap_inc(int'(wr_ptr), DEPTH));
      if (take)   rd_ptr <= AW'(wrap_inc(int'(rd_ptr), DEPTH));
      count <= CW'(next_count(int'(count), accept, take));
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/dual_pattern_fifo.sv
module dual_pattern_fifo #(
  parameter int DEPTH = 4,
  parameter int TW    = 8,
  parameter int PW    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ent_we,
  input  logic                          ent_sel,
  input  logic [TW-1:0]                 ent_timing,
  input  logic [PW-1:0]                 ent_pattern,
  input  logic                          csr_we,
  input  logic [dpf_pkg::CSR_WW-1:0]    csr_wdata,
  output logic [dpf_pkg::CSR_RW-1:0]    csr_rdata,
  input  logic [dpf_pkg::NUM_Q-1:0]     pop_req,
  output logic [dpf_pkg::NUM_Q-1:0]     head_valid,
  output logic [dpf_pkg::NUM_Q*TW-1:0]  head_timing,
  output logic [dpf_pkg::NUM_Q*PW-1:0]  head_pattern,
  output logic                          irq
);
  import dpf_pkg::*;
  localparam int EW = TW + PW;

  // Named internal events, observed by the bound checker.
  logic [NUM_Q-1:0] flush_cmd;
  logic [NUM_Q-1:0] ovf_evt;
  logic [NUM_Q-1:0] ovf_clr;
  logic [NUM_Q-1:0] ovf_q;
  logic [NUM_Q-1:0] full_q;
  logic [EW-1:0]    entry_in;

  assign entry_in = {ent_timing, ent_pattern};

  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    logic [EW-1:0] head;
    logic          push_i;

    assign push_i       = ent_we && (ent_sel == 1'(i));
    assign flush_cmd[i] = csr_we && csr_wdata[CLR_LSB+i];
    assign ovf_clr[i]   = csr_we && !csr_wdata[OVF_LSB+i];

    pattern_fifo #(.DEPTH(DEPTH), .EW(EW)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push_i),
      .pop      (pop_req[i]),
      .flush    (flush_cmd[i]),
      .din      (entry_in),
      .full     (full_q[i]),
      .valid    (head_valid[i]),
      .dout     (head),
      .overflow (ovf_evt[i])
    );

    sticky_flag u_ovf (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (ovf_evt[i]),
      .clr   (ovf_clr[i]),
      .q     (ovf_q[i])
    );

    assign head_timing[i*TW +: TW]  = head[EW-1 -: TW];
    assign head_pattern[i*PW +: PW] = head[PW-1:0];
  end

  always_comb begin
    csr_rdata = '0;
    csr_rdata[OVF_LSB  +: NUM_Q] = ovf_q;
    csr_rdata[FULL_LSB +: NUM_Q] = full_q;
  end

  assign irq = |ovf_q;
endmodule

// File: rtl/dual_pattern_fifo_chk.sv
module dual_pattern_fifo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ent_we,
  input logic       ent_sel,
  input logic       csr_we,
  input logic [3:0] csr_wdata,
  input logic [5:0] csr_rdata,
  input logic [1:0] pop_req,
  input logic [1:0] head_valid,
  input logic       irq,
  input logic [1:0] ovf_evt,
  input logic [1:0] flush_cmd
);
  // R5 and R7: an overflow event sets the flag whatever the CSR write does.
  a_r5_ovf1_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt[0] |=> csr_rdata[2]);
  a_r7_ovf2_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt[1] |=> csr_rdata[3]);

  a_r6_ovf1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata[2] && !(csr_we && !csr_wdata[2])) |=> csr_rdata[2]);
  a_r6_ovf2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata[3] && !(csr_we && !csr_wdata[3])) |=> csr_rdata[3]);
  a_r6_ovf1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && !csr_wdata[2] && !ovf_evt[0]) |=> !csr_rdata[2]);

  a_r4_full_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_we && !ent_sel && csr_rdata[4] && !flush_cmd[0]) |-> ovf_evt[0]);

  a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ovf_evt != 2'b00));

  a_r9_flush1_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush_cmd[0] |=> (!head_valid[0] && !csr_rdata[4]));
  a_r9_flush2_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush_cmd[1] |=> (!head_valid[1] && !csr_rdata[5]));

  a_r3_full_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[4] |-> head_valid[0]);

  a_r11_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (!head_valid[0] && pop_req[0] && !(ent_we && !ent_sel)) |=> !head_valid[0]);
endmodule

bind dual_pattern_fifo dual_pattern_fifo_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ent_we     (ent_we),
  .ent_sel    (ent_sel),
  .csr_we     (csr_we),
  .csr_wdata  (csr_wdata),
  .csr_rdata  (csr_rdata),
  .pop_req    (pop_req),
  .head_valid (head_valid),
  .irq        (irq),
  .ovf_evt    (ovf_evt),
  .flush_cmd  (flush_cmd)
);

// File: tb/sim_dual_pattern_fifo.sv
module sim_dual_pattern_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ent_we = 1'b0, ent_sel = 1'b0;
  logic [7:0]  ent_timing = '0, ent_pattern = '0;
  logic        csr_we = 1'b0;
  logic [3:0]  csr_wdata = '0;
  logic [5:0]  csr_rdata;
  logic [1:0]  pop_req = '0;
  logic [1:0]  head_valid;
  logic [15:0] head_timing, head_pattern;
  logic        irq;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_pattern_fifo u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference: two queues and two flag bits.
  logic [15:0] mq0[$], mq1[$];
  logic [1:0]  movf = '0;
  int          sz0, sz1;
  logic        fl0, fl1, ev0, ev1;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq0.delete(); mq1.delete(); movf = '0;
    end else begin
      sz0 = mq0.size(); sz1 = mq1.size();
      fl0 = csr_we && csr_wdata[0];
      fl1 = csr_we && csr_wdata[1];
      ev0 = ent_we && !ent_sel && sz0 == 4 && !fl0;
      ev1 = ent_we &&  ent_sel && sz1 == 4 && !fl1;
      if (fl0) mq0.delete();
      else begin
        if (pop_req[0] && sz0 > 0) void'(mq0.pop_front());
        if (ent_we && !ent_sel && sz0 < 4) mq0.push_back({ent_timing, ent_pattern});
      end
      if (fl1) mq1.delete();
      else begin
        if (pop_req[1] && sz1 > 0) void'(mq1.pop_front());
        if (ent_we && ent_sel && sz1 < 4) mq1.push_back({ent_timing, ent_pattern});
      end
      if (ev0) movf[0] = 1'b1; else if (csr_we && !csr_wdata[2]) movf[0] = 1'b0;
      if (ev1) movf[1] = 1'b1; else if (csr_we && !csr_wdata[3]) movf[1] = 1'b0;
    end
  end

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3 R5 R6 model status", 32'(csr_rdata),
            32'({mq1.size() == 4, mq0.size() == 4, movf, 2'b00}));
      check("R8 model irq", 32'(irq), 32'(|movf));
      check("R2 R10 model valid", 32'(head_valid), 32'({mq1.size() > 0, mq0.size() > 0}));
      if (mq0.size() > 0)
        check("R2 model head1", {16'h0, head_timing[7:0], head_pattern[7:0]}, 32'(mq0[0]));
      if (mq1.size() > 0)
        check("R2 model head2", {16'h0, head_timing[15:8], head_pattern[15:8]}, 32'(mq1[0]));
    end
  end

  task automatic push(bit q, logic [7:0] t, logic [7:0] p);
    ent_we = 1'b1; ent_sel = q; ent_timing = t; ent_pattern = p;
    @(negedge clk);
    ent_we = 1'b0;
  endtask

  task automatic csr_write(logic [3:0] v);
    csr_we = 1'b1; csr_wdata = v;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic pop(logic [1:0] m);
    pop_req = m;
    @(negedge clk);
    pop_req = '0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset csr", 32'(csr_rdata), 32'h0);
    check("R1 reset irq", 32'(irq), 32'h0);
    check("R1 reset empty", 32'(head_valid), 32'h0);

    for (int k = 0; k < 3; k++) push(1'b0, 8'h10 + 8'(k), 8'hA0 + 8'(k));
    check("R2 first head", {head_timing[7:0], head_pattern[7:0]}, 32'h10A0);
    check("R3 not yet full", 32'(csr_rdata), 32'h00);
    push(1'b0, 8'h13, 8'hA3);
    check("R3 full1 bit4", 32'(csr_rdata), 32'h10);
    push(1'b0, 8'hEE, 8'hEE);
    check("R5 ovf1 set", 32'(csr_rdata), 32'h14);
    check("R8 irq on ovf1", 32'(irq), 32'h1);
    csr_write(4'h4);
    check("R6 write1 keeps flag", 32'(csr_rdata), 32'h14);
    for (int k = 0; k < 4; k++) begin
      check("R4 order kept after drop", {head_timing[7:0], head_pattern[7:0]},
            32'(16'h10A0 + 16'h0101 * k));
      pop(2'b01);
    end
    check("R4 dropped entry absent", 32'(head_valid), 32'h0);
    check("R6 flag survives pops", 32'(csr_rdata), 32'h04);
    csr_write(4'h0);
    check("R6 write0 clears", 32'(csr_rdata), 32'h00);
    check("R8 irq low", 32'(irq), 32'h0);

    pop(2'b01);
    check("R11 empty pop ignored", 32'(head_valid), 32'h0);
    push(1'b0, 8'h55, 8'h66);
    check("R11 push after empty pop", {head_timing[7:0], head_pattern[7:0]}, 32'h5566);
    push(1'b0, 8'h77, 8'h88);
    csr_write(4'hC);
    check("R9 clr0 no effect", 32'(head_valid), 32'h1);
    check("R9 head unchanged", {head_timing[7:0], head_pattern[7:0]}, 32'h5566);

    for (int k = 0; k < 5; k++) push(1'b1, 8'h30 + 8'(k), 8'hC0 + 8'(k));
    check("R10 q2 full and ovf only", 32'(csr_rdata), 32'h28);
    check("R10 q1 head intact", {head_timing[7:0], head_pattern[7:0]}, 32'h5566);
    check("R10 q2 head", {head_timing[15:8], head_pattern[15:8]}, 32'h30C0);

    csr_write(4'h4);
    check("R7 pre flag cleared", 32'(csr_rdata[3]), 32'h0);
    ent_we = 1'b1; ent_sel = 1'b1; ent_timing = 8'hFF; ent_pattern = 8'hFF;
    csr_we = 1'b1; csr_wdata = 4'h0;
    @(negedge clk);
    ent_we = 1'b0; csr_we = 1'b0;
    check("R7 set beats clear", 32'(csr_rdata), 32'h28);

    csr_write(4'hA);
    check("R9 clr2 empties, reads 0", 32'(csr_rdata), 32'h08);
    check("R9 q2 empty q1 kept", 32'(head_valid), 32'h1);
    csr_write(4'hD);
    check("R9 clr1 empties", 32'(head_valid), 32'h0);
    push(1'b0, 8'h99, 8'h11);
    check("R9 pointer restarts", {head_timing[7:0], head_pattern[7:0]}, 32'h9911);
    csr_write(4'h0);
    check("R8 irq drops when both clear", 32'(irq), 32'h0);

    pop(2'b11);
    pop(2'b10);
    check("R11 q2 empty pop", 32'(head_valid), 32'h0);
    finish_run();
  end
endmodule